// File: doc/BRIEF.md
# SPI Flash Host with Shared Transfer FIFO

This block is a byte-wide register-mapped SPI master that performs exactly one flash transaction per start command. Software loads a command byte into a dedicated register, programs how many payload bytes to send and how many bytes to collect, places the payload in an 8-entry buffer through a single data port, and then sets the start bit. The block selects the flash, shifts the command byte followed by the payload, keeps clocking to collect the requested reply bytes, and then releases the select line.

Sent and collected bytes share one buffer. After a transaction the buffer holds the payload in its first entries and the reply bytes directly after them. Software rewinds the buffer pointer with a control bit, steps over the echoed payload, and then reads the reply. The pointer value can be read back, so software can confirm that a rewind has taken effect.

The serial side runs in SPI mode 0 at one quarter of the system clock. Register writes that would change the command, the counts or the buffer are dropped while a transaction is running.

Top module: `spi_fifo_host`

## Requirements
- R1: After reset, chip select is high, SCLK is low, and the registers at offsets 0x0, 0x1, 0x2, 0x3 and 0xD read as zero.
- R2: The command byte (offset 0x0) is the first byte on MOSI, most significant bit first, never taken from the buffer; SCLK is low whenever chip select is high, and MOSI does not change while SCLK is high (mode 0).
- R3: Offset 0x1 reads back as written; bits 3:0 give the payload count and bits 7:4 the reply count. The payload count is limited to 8, and the reply count to 8 minus the limited payload count.
- R4: Writing 1 to bit 0 of offset 0x2 while idle starts a transaction; bit 0 of offset 0x2 and bit 7 of offset 0x3 read 1 while it runs and 0 once it has finished.
- R5: Chip select stays low for exactly 32 system clocks per byte on the wire (command + payload + reply), with SCLK at system clock / 4.
- R6: Writing 1 to bit 4 of offset 0x2 returns the buffer pointer to zero; bits 2:0 of offset 0xD read zero on the next access.
- R7: Each read or accepted write at offset 0xC moves the pointer on by one entry, wrapping from 7 to 0; offset 0xD shows the pointer.
- R8: After a transaction, buffer entries 0 onwards hold the sent payload, followed by the reply bytes sampled MSB first on rising SCLK edges.
- R9: With a payload count of zero, the block clocks in exactly the programmed reply count and stores the replies from entry 0.
- R10: Writes to offsets 0x0, 0x1 and 0xC are ignored during a transaction; an ignored buffer write does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, valid in the same cycle |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Register reads are combinational, so a read is sampled in the same cycle its strobe is driven; the pointer, the command and the counts change at the clock edge that ends the access. The busy flag rises at the edge that accepts the start write and falls exactly 32 clocks per wire byte later, so the bench counts falling edges from the start write to the flag's fall and compares against the byte total. All samples are taken 1 ns after a falling clock edge, clear of the rising edge where state moves, and the flash model reacts only to SCLK and chip select edges.

// File: rtl/spi_fifo_host_pkg.sv
package spi_fifo_host_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] OFS_OPCODE = 4'h0;
    localparam logic [REG_AW-1:0] OFS_COUNTS = 4'h1;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 4'h2;
    localparam logic [REG_AW-1:0] OFS_STAT   = 4'h3;
    localparam logic [REG_AW-1:0] OFS_DATA   = 4'hC;
    localparam logic [REG_AW-1:0] OFS_PTR    = 4'hD;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_PCLR_BIT = 4;
    localparam int STAT_BUSY_BIT = 7;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_e;

endpackage

// File: rtl/spi_share_fifo.sv
module spi_share_fifo #(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_clr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic [PTR_W-1:0] ptr_o,
    input  logic [PTR_W-1:0] eng_idx,
    output logic [7:0]       eng_rdata,
    input  logic             eng_wr,
    input  logic [7:0]       eng_wdata
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      ptr;
    } fifo_s;

    fifo_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_wr) begin
            st_d.mem[st_q.ptr] = host_wdata;
        end
        if (eng_wr) begin
            st_d.mem[eng_idx] = eng_wdata;
        end
        if (ptr_clr) begin
            st_d.ptr = '0;
        end else if (host_wr || host_rd) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.mem[st_q.ptr];
    assign eng_rdata  = st_q.mem[eng_idx];
    assign ptr_o      = st_q.ptr;

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_fifo_host_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [7:0]       fifo_rdata,
    input  logic             miso,
    output logic             busy,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    output logic [PTR_W-1:0] fifo_idx,
    output logic             fifo_wr,
    output logic [7:0]       fifo_wdata
);

    localparam int IDX_W = $clog2(DEPTH + 2);

    typedef struct packed {
        eng_state_e       st;
        logic [1:0]       ph;
        logic [2:0]       bitn;
        logic [IDX_W-1:0] byte_i;
        logic [IDX_W-1:0] last;
        logic [IDX_W-1:0] txn;
        logic [7:0]       sh;
        logic             samp;
    } eng_s;

    eng_s st_d, st_q;

    logic [IDX_W-1:0] tx_lim;
    logic [IDX_W-1:0] rx_lim;
    logic [IDX_W-1:0] room;
    logic             in_reply;

    // Limit counts so that payload plus reply never exceed the buffer.
    always_comb begin
        if (32'(tx_cnt) > DEPTH) begin
            tx_lim = IDX_W'(DEPTH);
        end else begin
            tx_lim = IDX_W'(tx_cnt);
        end
        room = IDX_W'(DEPTH) - tx_lim;
        if (32'(rx_cnt) > 32'(room)) begin
            rx_lim = room;
        end else begin
            rx_lim = IDX_W'(rx_cnt);
        end
    end

    assign in_reply = (st_q.byte_i > st_q.txn);

    always_comb begin
        st_d       = st_q;
        fifo_wr    = 1'b0;
        fifo_wdata = {st_q.sh[6:0], st_q.samp};
        case (st_q.st)
            ENG_IDLE: begin
                if (start) begin
                    st_d.st     = ENG_SHIFT;
                    st_d.ph     = 2'd0;
                    st_d.bitn   = 3'd0;
                    st_d.byte_i = '0;
                    st_d.last   = tx_lim + rx_lim;
                    st_d.txn    = tx_lim;
                    st_d.sh     = opcode;
                end
            end
            default: begin
                st_d.ph = st_q.ph + 2'd1;
                if (st_q.ph == 2'd1) begin
                    st_d.samp = miso;
                end
                if (st_q.ph == 2'd3) begin
                    if (st_q.bitn != 3'd7) begin
                        st_d.sh   = {st_q.sh[6:0], st_q.samp};
                        st_d.bitn = st_q.bitn + 3'd1;
                    end else begin
                        st_d.bitn = 3'd0;
                        fifo_wr   = in_reply;
                        if (st_q.byte_i == st_q.last) begin
                            st_d.st = ENG_IDLE;
                        end else begin
                            st_d.byte_i = st_q.byte_i + 1'b1;
                            st_d.sh     = (st_q.byte_i < st_q.txn) ? fifo_rdata : 8'h00;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Reply byte k of the wire goes to entry k-1; payload byte k+1 comes from entry k.
    assign fifo_idx = in_reply ? PTR_W'(st_q.byte_i - 1'b1) : PTR_W'(st_q.byte_i);
    assign busy     = (st_q.st == ENG_SHIFT);
    assign cs_n     = ~busy;
    assign sclk     = busy & st_q.ph[1];
    assign mosi     = st_q.sh[7];

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_fifo_host_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [7:0]        fifo_rdata,
    output logic [7:0]        opcode,
    output logic [7:0]        counts,
    output logic              start,
    output logic              ptr_clr,
    output logic              fifo_wr,
    output logic              fifo_rd
);

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] counts;
    } regs_s;

    regs_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start   = 1'b0;
        ptr_clr = 1'b0;
        fifo_wr = 1'b0;
        fifo_rd = reg_rd && (reg_addr == OFS_DATA);
        if (reg_wr) begin
            case (reg_addr)
                OFS_OPCODE: if (!busy) st_d.opcode = reg_wdata;
                OFS_COUNTS: if (!busy) st_d.counts = reg_wdata;
                OFS_CTRL: begin
                    start   = reg_wdata[CTRL_GO_BIT] && !busy;
                    ptr_clr = reg_wdata[CTRL_PCLR_BIT];
                end
                OFS_DATA: fifo_wr = !busy;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        case (reg_addr)
            OFS_OPCODE: reg_rdata = st_q.opcode;
            OFS_COUNTS: reg_rdata = st_q.counts;
            OFS_CTRL:   reg_rdata[CTRL_GO_BIT] = busy;
            OFS_STAT:   reg_rdata[STAT_BUSY_BIT] = busy;
            OFS_DATA:   reg_rdata = fifo_rdata;
            OFS_PTR:    reg_rdata = {{(8 - PTR_W){1'b0}}, ptr};
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign opcode = st_q.opcode;
    assign counts = st_q.counts;

endmodule

// File: rtl/spi_fifo_host.sv
module spi_fifo_host
    import spi_fifo_host_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int PTR_W = $clog2(FIFO_DEPTH);
    localparam int CNT_W = 4;

    logic             busy;
    logic             start;
    logic             ptr_clr;
    logic             fifo_wr;
    logic             fifo_rd;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       host_rdata;
    logic [7:0]       opcode;
    logic [7:0]       counts;
    logic [PTR_W-1:0] eng_idx;
    logic [7:0]       eng_rdata;
    logic             eng_wr;
    logic [7:0]       eng_wdata;

    spi_host_regs #(
        .PTR_W(PTR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .ptr       (ptr),
        .fifo_rdata(host_rdata),
        .opcode    (opcode),
        .counts    (counts),
        .start     (start),
        .ptr_clr   (ptr_clr),
        .fifo_wr   (fifo_wr),
        .fifo_rd   (fifo_rd)
    );

    spi_share_fifo #(
        .DEPTH(FIFO_DEPTH),
        .PTR_W(PTR_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_clr   (ptr_clr),
        .host_wr   (fifo_wr),
        .host_rd   (fifo_rd),
        .host_wdata(reg_wdata),
        .host_rdata(host_rdata),
        .ptr_o     (ptr),
        .eng_idx   (eng_idx),
        .eng_rdata (eng_rdata),
        .eng_wr    (eng_wr),
        .eng_wdata (eng_wdata)
    );

    spi_xfer_engine #(
        .DEPTH(FIFO_DEPTH),
        .PTR_W(PTR_W),
        .CNT_W(CNT_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .tx_cnt    (counts[CNT_W-1:0]),
        .rx_cnt    (counts[2*CNT_W-1:CNT_W]),
        .fifo_rdata(eng_rdata),
        .miso      (spi_miso),
        .busy      (busy),
        .cs_n      (spi_cs_n),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .fifo_idx  (eng_idx),
        .fifo_wr   (eng_wr),
        .fifo_wdata(eng_wdata)
    );

endmodule

// File: rtl/spi_fifo_host_chk.sv
module spi_fifo_host_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sclk,
    input logic             mosi,
    input logic             busy,
    input logic             start,
    input logic             ptr_clr,
    input logic             fifo_wr,
    input logic             fifo_rd,
    input logic [PTR_W-1:0] ptr
);

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk) else $error("sclk active while deselected"); // R2

    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk) |-> $stable(mosi)) else $error("mosi moved while sclk high"); // R2

    AST_START_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !cs_n) else $error("start did not select flash"); // R4

    AST_SCLK_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> sclk) else $error("sclk high phase too short"); // R5

    AST_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (ptr == '0)) else $error("pointer not cleared"); // R6

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((fifo_wr || fifo_rd) && !ptr_clr) |=> (ptr == $past(ptr) + 1'b1)) else $error("pointer did not step"); // R7

    AST_NO_FIFO_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fifo_wr) else $error("host buffer write while busy"); // R10

endmodule

bind spi_fifo_host spi_fifo_host_chk #(
    .PTR_W(PTR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (spi_cs_n),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .busy   (busy),
    .start  (start),
    .ptr_clr(ptr_clr),
    .fifo_wr(fifo_wr),
    .fifo_rd(fifo_rd),
    .ptr    (ptr)
);

// File: tb/sim_spi_fifo_host.sv
`timescale 1ns/1ps
module sim_spi_fifo_host;

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  cnt;
        logic [63:0] pay;
        logic [71:0] pat;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{8'h9F, 8'h30, 64'h0, 72'h00_C2_20_18_00_00_00_00_00},
        '{8'h03, 8'h43, 64'h12_34_56_00_00_00_00_00, 72'hFF_FF_FF_FF_A1_B2_C3_D4_E5},
        '{8'h06, 8'h00, 64'h0, 72'h0},
        '{8'h02, 8'h08, 64'h01_23_45_67_89_AB_CD_EF, 72'h0},
        '{8'h0B, 8'hF5, 64'hDE_AD_BE_EF_5A_00_00_00, 72'h00_11_22_33_44_55_96_69_3C},
        '{8'hA5, 8'h2C, 64'h80_40_20_10_08_04_02_01, 72'h0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    logic [71:0] cur_pat = '0;
    logic [71:0] sl_out = '0;
    logic [71:0] sl_in = '0;
    int          sl_bits = 0;

    always #2 clk = ~clk;

    spi_fifo_host u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // Flash model: mode 0, presents bits of cur_pat, records MOSI.
    always @(negedge spi_cs_n) begin
        sl_out   = cur_pat;
        spi_miso = cur_pat[71];
        sl_in    = '0;
        sl_bits  = 0;
    end
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            sl_in   = {sl_in[70:0], spi_mosi};
            sl_bits = sl_bits + 1;
        end
    end
    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            sl_out   = {sl_out[70:0], 1'b0};
            spi_miso = sl_out[71];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic go_and_time(output int cyc);
        wr(4'h2, 8'h01);
        reg_addr = 4'h3;
        cyc = 0;
        #1;
        while (reg_rdata[7] && cyc < 5000) begin
            @(negedge clk);
            #1;
            cyc++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 cs_n", 32'(spi_cs_n), 32'd1);
        check("R1 sclk", 32'(spi_sclk), 32'd0);
        rd(4'h0, d); check("R1 opcode", 32'(d), 32'h0);
        rd(4'h1, d); check("R1 counts", 32'(d), 32'h0);
        rd(4'h2, d); check("R1 ctrl", 32'(d), 32'h0);
        rd(4'h3, d); check("R1 status", 32'(d), 32'h0);
        rd(4'hD, d); check("R1 pointer", 32'(d), 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            int txr, rxr, txe, rxe, nb;
            txr = int'(VEC[v].cnt[3:0]);
            rxr = int'(VEC[v].cnt[7:4]);
            txe = (txr > 8) ? 8 : txr;
            rxe = (rxr > 8 - txe) ? 8 - txe : rxr;
            nb  = 1 + txe + rxe;
            cur_pat = VEC[v].pat;
            wr(4'h0, VEC[v].op);
            wr(4'h1, VEC[v].cnt);
            rd(4'h1, d); check("R3 counts readback", 32'(d), 32'(VEC[v].cnt));
            wr(4'h2, 8'h10);
            for (int i = 0; i < txe; i++) wr(4'hC, VEC[v].pay[63-8*i -: 8]);
            rd(4'hD, d); check("R7 pointer after payload", 32'(d), 32'(txe % 8));
            go_and_time(cyc);
            check("R5 select length", 32'(cyc), 32'(32 * nb));
            rd(4'h2, d); check("R4 start cleared", 32'(d), 32'h0);
            check("R5 bits on wire", 32'(sl_bits), 32'(8 * nb));
            check("R2 opcode first", 32'(sl_in[8*(nb-1) +: 8]), 32'(VEC[v].op));
            for (int k = 1; k <= txe; k++)
                check("R8 payload on wire", 32'(sl_in[8*(nb-1-k) +: 8]), 32'(VEC[v].pay[63-8*(k-1) -: 8]));
            wr(4'h2, 8'h10);
            for (int i = 0; i < txe + rxe; i++) begin
                rd(4'hC, d);
                if (i < txe)
                    check("R8 echoed payload", 32'(d), 32'(VEC[v].pay[63-8*i -: 8]));
                else if (txe == 0)
                    check("R9 reply from entry 0", 32'(d), 32'(VEC[v].pat[71-8*(1+i) -: 8]));
                else
                    check("R8 reply after payload", 32'(d), 32'(VEC[v].pat[71-8*(1+i) -: 8]));
            end
        end

        // R6: pointer rewind
        wr(4'h2, 8'h10);
        wr(4'hC, 8'h11); wr(4'hC, 8'h22); wr(4'hC, 8'h33);
        rd(4'hD, d); check("R7 pointer steps", 32'(d), 32'd3);
        wr(4'h2, 8'h10);
        rd(4'hD, d); check("R6 pointer zero", 32'(d), 32'd0);

        // R7: wrap after nine reads
        for (int i = 0; i < 9; i++) rd(4'hC, d);
        rd(4'hD, d); check("R7 pointer wrap", 32'(d), 32'd1);

        // R10: writes ignored while busy
        cur_pat = 72'h0;
        wr(4'h0, 8'h55);
        wr(4'h1, 8'h20);
        wr(4'h2, 8'h10);
        wr(4'h2, 8'h01);
        wr(4'h0, 8'hEE);
        wr(4'h1, 8'h11);
        wr(4'hC, 8'h77);
        rd(4'hD, d); check("R10 pointer held", 32'(d), 32'd0);
        rd(4'h2, d); check("R4 start reads busy", 32'(d), 32'd1);
        rd(4'h3, d); check("R4 busy flag", 32'(d), 32'h80);
        cyc = 0;
        reg_addr = 4'h3;
        #1;
        while (reg_rdata[7] && cyc < 5000) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd(4'h0, d); check("R10 opcode kept", 32'(d), 32'h55);
        rd(4'h1, d); check("R10 counts kept", 32'(d), 32'h20);
        check("R10 opcode on wire", 32'(sl_in[23:16]), 32'h55);
        check("R1 cs_n released", 32'(spi_cs_n), 32'd1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule